// File: doc/BRIEF.md
# Dual Temperature Sensor Serial Reader

This block reads two serial temperature sensors in one pass. Both sensors listen on a shared serial clock and a shared select line, and each returns its bits on a data pin of its own. A single start pulse runs one frame. The frame opens with select high for two clock pulses. Select then falls while the clock is low. Sixteen clock pulses follow with select low, during which both data pins are captured together, most significant bit first. The frame closes with two more clock pulses with select high.

Each 16-bit raw code is read as a two's-complement number. Its temperature, in steps of 1/32 °C, is the code shifted right arithmetically by two places. A code of all ones or all zeros shows that the sensor is missing or broken. Such a reading is marked invalid and reported as zero. Both readings and their valid flags update together, in the same cycle as a one-cycle done pulse. They then hold until the next frame completes. Each half of the serial clock lasts `HALF_CYC` system clocks.

Top module: `dual_temp_reader`

## Requirements
- R1: After reset, and while reset is held even in the middle of a frame, the serial clock is low, select is high, done is low, and both valid flags and both temperatures are zero.
- R2: A frame begins with exactly two rising serial-clock edges while select is high. Select then falls, and when it falls the serial clock is low.
- R3: While select is low, exactly 16 rising serial-clock edges occur, and select stays low across all of them.
- R4: Both data pins are sampled while the serial clock is high. The first bit sampled becomes bit 15 of the code and the last becomes bit 0, and the two sensors' codes are independent of each other.
- R5: After the data bits, exactly two more rising serial-clock edges occur with select high. The frame ends with the clock low and select high.
- R6: For a valid code, the reported temperature is a 14-bit signed value equal to the 16-bit two's-complement code shifted right arithmetically by 2 (1 LSB = 0.03125 °C). Example: 0x0190 gives +100, and 0xFE70 gives -100.
- R7: A code of 0xFFFF or 0x0000 makes that sensor's valid flag 0 and its temperature 0. The other sensor's result is not affected.
- R8: Done is high for exactly one cycle per frame. Temperatures and valid flags change only in the cycle in which done is high, and otherwise hold.
- R9: A start pulse that arrives while a frame is in progress has no effect: the frame's length, pin sequence and results are unchanged, and only one done pulse occurs.
- R10: If start is sampled high at clock edge E, with the block idle, then done is high right after edge E + 41*HALF_CYC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that starts a frame when the block is idle |
| sns_sclk | output | 1 | Shared serial clock to both sensors |
| sns_sel | output | 1 | Shared select line to both sensors |
| sns_dat | input | 2 | Serial data, bit 0 from sensor A, bit 1 from sensor B |
| temp_a | output | 14 | Sensor A temperature, signed, 1/32 °C per LSB |
| valid_a | output | 1 | Sensor A reading is valid |
| temp_b | output | 14 | Sensor B temperature, signed, 1/32 °C per LSB |
| valid_b | output | 1 | Sensor B reading is valid |
| done | output | 1 | One-cycle pulse when both readings update |

## Verification
If the phase counter is off by one, the pin sequence shows it within the same frame: the count of clock edges in the preamble, data or closing group changes, or done arrives earlier or later than 41 half-periods after start. A fault in the sampling strobe or in the shift direction garbles asymmetric codes such as 0x5A5A and 0x0190, and the error is visible at the done pulse of that same frame. Faults in the conversion show up on the boundary codes 0x8000, 0x7FFF, 0xFFFC and 0x0003 and on the two invalid codes. Those codes are applied to one sensor at a time so that a swapped or shared lane is also exposed.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    localparam int CODE_W   = 16;
    localparam int TEMP_W   = CODE_W - 2;
    localparam int NSENS    = 2;
    localparam int PRE_PH   = 5;
    localparam int DATA_PH  = 2 * CODE_W;
    localparam int POST_PH  = 4;
    localparam int TOTAL_PH = PRE_PH + DATA_PH + POST_PH;

    typedef struct packed {
        logic                     ok;
        logic signed [TEMP_W-1:0] temp;
    } reading_t;

    typedef struct packed {
        logic sclk;
        logic sel;
    } pins_t;

    // Pin levels held during frame phase p (each phase is one half-period)
    function automatic pins_t phase_pins(input int p);
        pins_t r;
        int    q;
        if (p < PRE_PH) begin
            r.sclk = p[0];
            r.sel  = (p != PRE_PH - 1);
        end else if (p < PRE_PH + DATA_PH) begin
            q      = p - PRE_PH;
            r.sclk = ~q[0];
            r.sel  = 1'b0;
        end else begin
            q      = p - PRE_PH - DATA_PH;
            r.sclk = ~q[0];
            r.sel  = 1'b1;
        end
        return r;
    endfunction

    function automatic logic is_sample_phase(input int p);
        int q;
        q = p - PRE_PH;
        return (p >= PRE_PH) && (p < PRE_PH + DATA_PH) && (q[0] == 1'b0);
    endfunction

    function automatic reading_t convert(input logic [CODE_W-1:0] code);
        reading_t r;
        r.ok   = (code != '0) && (code != '1);
        r.temp = r.ok ? code[CODE_W-1:2] : '0;
        return r;
    endfunction
endpackage

// File: rtl/tsr_tick.sv
module tsr_tick #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tsr_seq.sv
module tsr_seq
    import tsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic sclk,
    output logic sel,
    output logic sample,
    output logic finish
);
    localparam int PW = $clog2(TOTAL_PH);

    logic [PW-1:0] phase_q;
    logic          busy_q;
    pins_t         pins;
    logic          last_ph;

    assign last_ph = (int'(phase_q) == TOTAL_PH - 1);
    assign busy    = busy_q;
    assign finish  = busy_q && tick && last_ph;
    assign sample  = busy_q && tick && is_sample_phase(int'(phase_q));

    always_comb begin
        if (busy_q) pins = phase_pins(int'(phase_q));
        else        pins = '{sclk: 1'b0, sel: 1'b1};
    end
    assign sclk = pins.sclk;
    assign sel  = pins.sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                phase_q <= '0;
            end
        end else if (tick) begin
            if (last_ph) busy_q  <= 1'b0;
            else         phase_q <= phase_q + 1'b1;
        end
    end

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start && !finish) |=> (busy_q && phase_q >= $past(phase_q))) else $error("start restarted frame"); // R9
    AST_SAMPLE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        sample |-> (sclk && !sel)) else $error("sample outside high data phase"); // R4
endmodule

// File: rtl/dual_temp_reader.sv
module dual_temp_reader
    import tsr_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              sns_sclk,
    output logic              sns_sel,
    input  logic [1:0]        sns_dat,
    output logic [TEMP_W-1:0] temp_a,
    output logic              valid_a,
    output logic [TEMP_W-1:0] temp_b,
    output logic              valid_b,
    output logic              done
);
    logic busy, tick, sample, finish;
    logic done_q;

    tsr_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk (clk),
        .rst (rst),
        .run (busy),
        .tick(tick)
    );

    tsr_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tick  (tick),
        .busy  (busy),
        .sclk  (sns_sclk),
        .sel   (sns_sel),
        .sample(sample),
        .finish(finish)
    );

    reading_t rd_q [NSENS];

    for (genvar i = 0; i < NSENS; i++) begin : g_lane
        logic [CODE_W-1:0] shift_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                shift_q  <= '0;
                rd_q[i]  <= '0;
            end else begin
                if (sample) shift_q <= {shift_q[CODE_W-2:0], sns_dat[i]};
                if (finish) rd_q[i] <= convert(shift_q);
            end
        end

        AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
            !rd_q[i].ok |-> (rd_q[i].temp == '0)) else $error("invalid reading not zero"); // R7
        AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
            !done_q |-> $stable(rd_q[i])) else $error("reading changed without done"); // R8
    end

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= finish;
    end

    assign done    = done_q;
    assign temp_a  = rd_q[0].temp;
    assign valid_a = rd_q[0].ok;
    assign temp_b  = rd_q[1].temp;
    assign valid_b = rd_q[1].ok;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q) else $error("done longer than one cycle"); // R8
    AST_SEL_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(sns_sel) |-> !sns_sclk) else $error("select fell with clock high"); // R2
endmodule

// File: tb/dual_temp_reader_tb.sv
module dual_temp_reader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int FRAME_CYC  = 41 * HALF;
    localparam int NVEC       = 8;
    localparam logic [31:0] VEC [0:NVEC-1] = '{
        32'h0190_FFFF, 32'h0000_FE70, 32'h8000_7FFF, 32'hFFFC_0003,
        32'hFFFE_0004, 32'h5A5A_A5A5, 32'hFFFF_0000, 32'h0001_8001
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic sns_sclk, sns_sel, valid_a, valid_b, done;
    logic [1:0]  sns_dat = 2'b00;
    logic [13:0] temp_a, temp_b;

    int n_tests = 0, n_fail = 0;
    logic [15:0] cur_a = 16'h0, cur_b = 16'h0;
    int bit_idx = 0, pre_r = 0, dat_r = 0, post_r = 0;
    bit seen_low = 0, fall_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_temp_reader #(.HALF_CYC(HALF)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .sns_sclk(sns_sclk), .sns_sel(sns_sel), .sns_dat(sns_dat),
        .temp_a(temp_a), .valid_a(valid_a),
        .temp_b(temp_b), .valid_b(valid_b), .done(done)
    );

    // Sensor model: presents next bit on each rising clock with select low
    always @(posedge sns_sclk) begin
        if (!sns_sel) begin
            if (bit_idx < 16) sns_dat = {cur_b[15 - bit_idx], cur_a[15 - bit_idx]};
            bit_idx++;
            dat_r++;
        end else if (seen_low) post_r++;
        else pre_r++;
    end
    always @(negedge sns_sel) begin
        bit_idx  = 0;
        seen_low = 1;
        if (sns_sclk) fall_bad = 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_temp(input logic [15:0] c);
        if (c == 16'h0000 || c == 16'hFFFF) return 0;
        return int'($signed(c)) >>> 2;
    endfunction

    function automatic int exp_valid(input logic [15:0] c);
        return (c == 16'h0000 || c == 16'hFFFF) ? 0 : 1;
    endfunction

    task automatic run_frame(input logic [15:0] a, input logic [15:0] b, input bit extra_start);
        int cyc = 0;
        int dn = 0;
        cur_a = a; cur_b = b;
        pre_r = 0; dat_r = 0; post_r = 0; seen_low = 0; fall_bad = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (extra_start && cyc == 60) start = 1'b1;
            if (extra_start && cyc == 61) start = 1'b0;
        end
        chk(cyc == FRAME_CYC, "R10 frame length", cyc, FRAME_CYC);
        if (extra_start) chk(cyc == FRAME_CYC, "R9 length with extra start", cyc, FRAME_CYC);
        chk(pre_r == 2, "R2 preamble clocks", pre_r, 2);
        chk(!fall_bad, "R2 select fell with clock low", int'(fall_bad), 0);
        chk(dat_r == 16, "R3 data clocks", dat_r, 16);
        chk(post_r == 2, "R5 closing clocks", post_r, 2);
        chk(!sns_sclk && sns_sel, "R5 idle pins at end", {sns_sclk, sns_sel}, 1);
        chk(int'(valid_a) == exp_valid(a), "R7 valid_a", int'(valid_a), exp_valid(a));
        chk(int'(valid_b) == exp_valid(b), "R7 valid_b", int'(valid_b), exp_valid(b));
        chk(int'($signed(temp_a)) == exp_temp(a), "R4 R6 temp_a", int'($signed(temp_a)), exp_temp(a));
        chk(int'($signed(temp_b)) == exp_temp(b), "R4 R6 temp_b", int'($signed(temp_b)), exp_temp(b));
        @(negedge clk);
        chk(!done, "R8 done single cycle", int'(done), 0);
        repeat (20) begin
            @(negedge clk);
            if (done) dn++;
        end
        chk(dn == 0, "R9 R8 no second done", dn, 0);
        chk(int'($signed(temp_a)) == exp_temp(a) && int'($signed(temp_b)) == exp_temp(b),
            "R8 outputs hold", int'($signed(temp_a)), exp_temp(a));
    endtask

    initial begin
        repeat (5000 * 10) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!sns_sclk && sns_sel && !done, "R1 reset pins", {sns_sclk, sns_sel, done}, 1);
        chk(!valid_a && !valid_b && temp_a == 0 && temp_b == 0, "R1 reset outputs",
            {valid_a, valid_b}, 0);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) run_frame(VEC[i][31:16], VEC[i][15:0], 1'b0);
        // Start during a frame must be ignored
        run_frame(16'h1234, 16'hEDCC, 1'b1);
        // Reset in the middle of a frame
        cur_a = 16'h0190; cur_b = 16'h0190;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (90) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!sns_sclk && sns_sel && !done, "R1 mid-frame reset pins", {sns_sclk, sns_sel, done}, 1);
        chk(!valid_a && !valid_b && temp_a == 0 && temp_b == 0, "R1 mid-frame reset outputs",
            {valid_a, valid_b}, 0);
        rst = 1'b0;
        @(negedge clk);
        run_frame(16'h0190, 16'hFE70, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule